// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the bus-facing register bank of a classic serial port, reduced to the registers that software sets up and reads back. A requester hands it one access at a time: a byte address, a byte length and up to `MAX_WORDS` 32-bit write words. The block walks the access one 32-bit word per cycle at a 4-byte stride. It stores the divisor, interrupt-enable, line-control and scratch values. When software writes the transmit slot, the block sends the character out on a byte stream with a valid/ready handshake.

The divisor bytes share the two lowest register slots with the transmit/receive slot and the interrupt-enable register. Bit 7 of the line-control value selects which pair is visible. Receive data, interrupt identification, modem control and both status registers are fixed at zero. Serial timing, FIFOs and interrupt generation are not part of this block. When the access is finished the block raises `req_ready` for one cycle, with the read words on `rsp_rdata`.

Top module: `uart_fe_top`

## Requirements
- R1: After reset all stored registers are zero, so the divisor-select bit is clear. `tx_valid` and `req_ready` are low.
- R2: Only the low 16 bits of the address select a register. Stored registers are 8 bits wide: the low byte of a write is kept, and bits 31:8 read as zero. The scratch slot at offset 0x1C reads back the last byte written to it.
- R3: Offset 0x0C holds the line-control byte and reads it back in full. Its bit 7 is the divisor-select bit, and every write to 0x0C updates it.
- R4: While the divisor-select bit is 1, offsets 0x00 and 0x04 read and write the low and high divisor bytes, and nothing is transmitted.
- R5: While the divisor-select bit is 0, a write to offset 0x00 sends its low byte on `tx_data`, and a read of 0x00 returns zero. Offset 0x04 is then the interrupt-enable byte, which can be read and written.
- R6: Offsets 0x08, 0x10, 0x14 and 0x18, and every offset that maps to no register, read as zero. Writes to them change nothing.
- R7: Some accesses are rejected: an address with bits 1:0 not zero, a byte length with bits 1:0 not zero, or a length above 4*MAX_WORDS. A rejected read returns all zeros. A rejected write sends nothing and changes no register.
- R8: An access of N words touches offsets base, base+4, …, base+4(N-1) in that order, each word on its own. Read word i is returned in `rsp_rdata[32i+31:32i]`. A divisor-select change made by one word applies to the words after it.
- R9: `tx_flush` is high with a transmitted byte exactly when that byte is 0x0A.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold, and the access does not complete. No character is dropped.
- R11: `req_ready` is high for exactly one cycle per accepted request. A zero-length request completes with no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | ADDR_W | Byte address of the first word |
| req_bytes | input | LEN_W | Access length in bytes |
| req_wdata | input | 32*MAX_WORDS | Write words, word i in bits 32i+31:32i |
| req_ready | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 32*MAX_WORDS | Read words, valid while `req_ready` is high |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Transmit byte taken by the sink |
| tx_data | output | 8 | Transmit byte |
| tx_flush | output | 1 | Byte is a newline |

## Verification
The hardest case to reach from the ports is one multi-word write that sends a character while the sink holds back. It must stall part way through, and a later word in the same access must flip the divisor-select bit. The bench starts a four-word write at offset 0x00 with `tx_ready` held low. It watches the offered byte stay stable and `req_ready` stay low, then releases the sink. A four-word read that follows must show the divisor bytes rather than the interrupt-enable value. A behavioural model with a byte queue predicts every transmitted byte and every read word.

// File: rtl/uart_fe_pkg.sv
// Shared offsets and types for the serial-port register front end.
// Assumes 17-bit word offsets: bit 16 set means the offset ran past the
// 16-bit window and maps to no register.
package uart_fe_pkg;

    localparam int WORD_W = 32;
    localparam int OFF_W  = 17;

    localparam logic [OFF_W-1:0] OFF_DATA  = 17'h0_0000;
    localparam logic [OFF_W-1:0] OFF_IEN   = 17'h0_0004;
    localparam logic [OFF_W-1:0] OFF_IID   = 17'h0_0008;
    localparam logic [OFF_W-1:0] OFF_LCTL  = 17'h0_000C;
    localparam logic [OFF_W-1:0] OFF_MCTL  = 17'h0_0010;
    localparam logic [OFF_W-1:0] OFF_LSTAT = 17'h0_0014;
    localparam logic [OFF_W-1:0] OFF_MSTAT = 17'h0_0018;
    localparam logic [OFF_W-1:0] OFF_SCR   = 17'h0_001C;

    localparam int SEL_BIT = 7;   // divisor-select bit inside line control

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/uart_fe_regs.sv
// Register storage and single-word decode.
// What it does: holds divisor low/high, interrupt enable, line control and
// scratch; returns the read value for the offset presented; flags the
// transmit slot. Assumes one word access per cycle, presented on acc_off.
module uart_fe_regs
    import uart_fe_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  acc_off,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              div_sel,
    output logic              tx_slot
);

    localparam int PAD_W = WORD_W - REG_W;

    logic [REG_W-1:0] div_lo_q, div_hi_q, ien_q, lctl_q, scr_q;

    // Storage update for the writable slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_lo_q <= '0;
            div_hi_q <= '0;
            ien_q    <= '0;
            lctl_q   <= '0;
            scr_q    <= '0;
        end else if (wr_en) begin
            unique case (acc_off)
                OFF_DATA: if (div_sel) div_lo_q <= wr_data[REG_W-1:0];
                OFF_IEN: begin
                    if (div_sel) div_hi_q <= wr_data[REG_W-1:0];
                    else         ien_q    <= wr_data[REG_W-1:0];
                end
                OFF_LCTL: lctl_q <= wr_data[REG_W-1:0];
                OFF_SCR:  scr_q  <= wr_data[REG_W-1:0];
                default: ;
            endcase
        end
    end

    assign div_sel = lctl_q[SEL_BIT];
    assign tx_slot = (acc_off == OFF_DATA) && !div_sel;

    // Read mux: banked slots, stored slots, zero for everything else.
    always_comb begin
        rd_data = '0;
        unique case (acc_off)
            OFF_DATA: if (div_sel) rd_data = {{PAD_W{1'b0}}, div_lo_q};
            OFF_IEN:  rd_data = div_sel ? {{PAD_W{1'b0}}, div_hi_q}
                                        : {{PAD_W{1'b0}}, ien_q};
            OFF_LCTL: rd_data = {{PAD_W{1'b0}}, lctl_q};
            OFF_SCR:  rd_data = {{PAD_W{1'b0}}, scr_q};
            default:  rd_data = '0;
        endcase
    end

    // R3: a line-control write sets the select bit from data bit 7.
    a_r3_sel_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && acc_off == OFF_LCTL) |=> (div_sel == $past(wr_data[SEL_BIT])));

endmodule

// File: rtl/uart_fe_seq.sv
// Access sequencer.
// What it does: accepts one request, rejects malformed ones, walks the words
// in ascending order one per cycle, stalls on the transmit handshake, collects
// read words and strobes completion. Assumes req_* hold while req_valid is
// high and until req_ready is seen.
module uart_fe_seq
    import uart_fe_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 8,
    parameter int MAX_WORDS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [LEN_W-1:0]            req_bytes,
    input  logic [WORD_W*MAX_WORDS-1:0] req_wdata,
    output logic                        req_ready,
    output logic [WORD_W*MAX_WORDS-1:0] rsp_rdata,
    output logic [OFF_W-1:0]            acc_off,
    output logic                        wr_en,
    output logic [WORD_W-1:0]           wr_data,
    input  logic [WORD_W-1:0]           rd_data,
    input  logic                        tx_slot,
    output logic                        tx_valid,
    input  logic                        tx_ready,
    output logic [7:0]                  tx_data,
    output logic                        tx_flush
);

    localparam int NW_W  = $clog2(MAX_WORDS + 1);
    localparam int IDX_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;
    localparam logic [LEN_W-1:0] MAX_BYTES = LEN_W'(MAX_WORDS * 4);

    seq_state_e                  state_q;
    logic [15:0]                 base_q;
    logic [NW_W-1:0]             nw_q;
    logic [IDX_W-1:0]            idx_q;
    logic                        wr_q;
    logic [WORD_W*MAX_WORDS-1:0] wdata_q;

    logic            accept, req_bad, in_run, want_tx, step, last;
    logic [NW_W-1:0] req_nw;

    assign accept  = (state_q == SEQ_IDLE) && req_valid;
    assign req_bad = (req_addr[1:0] != 2'b00) || (req_bytes[1:0] != 2'b00)
                   || (req_bytes > MAX_BYTES);
    assign req_nw  = NW_W'(req_bytes >> 2);
    assign in_run  = (state_q == SEQ_RUN);
    assign want_tx = in_run && wr_q && tx_slot;
    assign step    = in_run && (!want_tx || tx_ready);
    assign last    = ((NW_W'(idx_q) + NW_W'(1)) == nw_q);

    assign acc_off = {1'b0, base_q} + OFF_W'({idx_q, 2'b00});
    assign wr_data = wdata_q[idx_q*WORD_W +: WORD_W];
    assign wr_en   = step && wr_q;

    assign tx_valid  = want_tx;
    assign tx_data   = wr_data[7:0];
    assign tx_flush  = (wr_data[7:0] == 8'h0A);
    assign req_ready = (state_q == SEQ_DONE);

    // Request latch and word walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            base_q  <= '0;
            nw_q    <= '0;
            idx_q   <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: if (req_valid) begin
                    base_q  <= req_addr[15:0];
                    nw_q    <= req_nw;
                    idx_q   <= '0;
                    wr_q    <= req_write;
                    wdata_q <= req_wdata;
                    state_q <= (req_bad || req_nw == '0) ? SEQ_DONE : SEQ_RUN;
                end
                SEQ_RUN: if (step) begin
                    idx_q <= idx_q + IDX_W'(1);
                    if (last) state_q <= SEQ_DONE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // One read-word slot per possible word of an access.
    for (genvar g = 0; g < MAX_WORDS; g++) begin : g_slot
        logic [WORD_W-1:0] slot_q;
        // Capture read data for word g; clear at the start of each request.
        always_ff @(posedge clk) begin
            if (!rst_n || accept)
                slot_q <= '0;
            else if (step && !wr_q && idx_q == IDX_W'(g))
                slot_q <= rd_data;
        end
        assign rsp_rdata[g*WORD_W +: WORD_W] = slot_q;
    end

    // R10: an offered byte holds until it is taken.
    a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R10: no completion while a byte is waiting.
    a_r10_no_done_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> !req_ready);

    // R11: completion strobe lasts one cycle.
    a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

endmodule

// File: rtl/uart_fe_top.sv
// Serial-port register front end, top level.
// What it does: joins the access sequencer to the register storage and
// exposes the request port and the transmit byte stream. Assumes a single
// requester that holds its request until the completion strobe.
module uart_fe_top
    import uart_fe_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 8,
    parameter int MAX_WORDS = 4,
    parameter int REG_W     = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [LEN_W-1:0]            req_bytes,
    input  logic [WORD_W*MAX_WORDS-1:0] req_wdata,
    output logic                        req_ready,
    output logic [WORD_W*MAX_WORDS-1:0] rsp_rdata,
    output logic                        tx_valid,
    input  logic                        tx_ready,
    output logic [7:0]                  tx_data,
    output logic                        tx_flush
);

    logic [OFF_W-1:0]  acc_off;
    logic              wr_en;
    logic [WORD_W-1:0] wr_data;
    logic [WORD_W-1:0] rd_data;
    logic              div_sel;
    logic              tx_slot;

    uart_fe_seq #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .MAX_WORDS (MAX_WORDS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_bytes (req_bytes),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_rdata (rsp_rdata),
        .acc_off   (acc_off),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .tx_slot   (tx_slot),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_data   (tx_data),
        .tx_flush  (tx_flush)
    );

    uart_fe_regs #(
        .REG_W (REG_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_off (acc_off),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .div_sel (div_sel),
        .tx_slot (tx_slot)
    );

    // R5: characters leave only while the divisor bank is hidden.
    a_r5_tx_needs_sel_clear: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !div_sel);

    // R1: leaving reset, nothing is offered or completed and the bank is hidden.
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!tx_valid && !req_ready && !div_sel));

endmodule

// File: tb/uart_fe_top_bench.sv
`timescale 1ns/1ps
module uart_fe_top_bench;

    localparam int MAXW = 4;
    localparam int DW   = 32 * MAXW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [31:0]   req_addr = '0;
    logic [7:0]    req_bytes = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic [DW-1:0] rsp_rdata;
    logic          tx_valid;
    logic          tx_ready = 1'b1;
    logic [7:0]    tx_data;
    logic          tx_flush;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    int m_div_lo = 0, m_div_hi = 0, m_ien = 0, m_lctl = 0, m_scr = 0;
    byte unsigned tx_q[$];

    always #2.5 clk = ~clk;

    uart_fe_top u_uart_fe_top (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_bytes(req_bytes), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_flush(tx_flush)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // model of one access; returns expected read words, queues expected bytes
    function automatic logic [DW-1:0] model(input bit wr, input logic [31:0] addr,
                                            input int nbytes, input logic [DW-1:0] wd);
        logic [DW-1:0] rd = '0;
        if (addr[1:0] != 0 || nbytes % 4 != 0 || nbytes > 4 * MAXW) return rd;
        for (int i = 0; i < nbytes / 4; i++) begin
            int off = int'(addr[15:0]) + 4 * i;
            int w   = int'(wd[32*i +: 8]);
            bit sel = m_lctl[7];
            if (wr) begin
                case (off)
                    'h00: if (sel) m_div_lo = w; else tx_q.push_back(byte'(w));
                    'h04: if (sel) m_div_hi = w; else m_ien = w;
                    'h0C: m_lctl = w;
                    'h1C: m_scr = w;
                    default: ;
                endcase
            end else begin
                int v = 0;
                case (off)
                    'h00: v = sel ? m_div_lo : 0;
                    'h04: v = sel ? m_div_hi : m_ien;
                    'h0C: v = m_lctl;
                    'h1C: v = m_scr;
                    default: v = 0;
                endcase
                rd[32*i +: 32] = 32'(v);
            end
        end
        return rd;
    endfunction

    // drive one request, wait for completion, compare read words
    task automatic access(input string req, input bit wr, input logic [31:0] addr,
                          input int nbytes, input logic [DW-1:0] wd);
        logic [DW-1:0] exp;
        exp = model(wr, addr, nbytes, wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr;
        req_bytes = 8'(nbytes); req_wdata = wd;
        do @(negedge clk); while (!req_ready);
        if (!wr) check(rsp_rdata == exp, req, rsp_rdata, exp);
        req_valid = 1'b0;
        @(negedge clk);
        check(!req_ready, "R11 ready pulse", 128'(req_ready), 128'(0));
    endtask

    // every clock: compare any byte taken against the model queue
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (tx_q.size() == 0) begin
                check(1'b0, "R5 unexpected byte", 128'(tx_data), 128'(0));
            end else begin
                byte unsigned e;
                e = tx_q.pop_front();
                check(tx_data == e, "R5 tx byte", 128'(tx_data), 128'(e));
                check(tx_flush == (e == 8'h0A), "R9 flush", 128'(tx_flush),
                      128'(e == 8'h0A));
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 128'(0), 128'(1));
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!req_ready && !tx_valid, "R1 outputs idle", 128'({req_ready, tx_valid}), 128'(0));
        rst_n = 1'b1;
        access("R1 lctl zero", 0, 32'h0C, 4, '0);
        access("R1 ien/sel zero", 0, 32'h00, 8, '0);

        // R2: scratch, upper address bits ignored, 8-bit storage
        access("R2 scr write", 1, 32'h1234_001C, 4, DW'(32'h0000_01A5));
        access("R2 scr read", 0, 32'h0000_001C, 4, '0);

        // R3/R4: select divisor bank, write both bytes, read back
        access("R3 lctl write", 1, 32'h0C, 4, DW'(32'h83));
        access("R3 lctl read", 0, 32'h0C, 4, '0);
        access("R4 div lo", 1, 32'h00, 4, DW'(32'h5A));
        access("R4 div hi", 1, 32'h04, 4, DW'(32'h01));
        access("R4 div read", 0, 32'h00, 8, '0);

        // R5: hidden bank, IER, transmit
        access("R3 lctl clear", 1, 32'h0C, 4, DW'(32'h03));
        access("R5 ien write", 1, 32'h04, 4, DW'(32'h0F));
        access("R5 read slots", 0, 32'h00, 8, '0);
        access("R5 tx H", 1, 32'h00, 4, DW'(32'h48));
        access("R9 tx newline", 1, 32'h00, 4, DW'(32'h0A));

        // R6: fixed-zero and unmapped offsets
        access("R6 write fixed", 1, 32'h10, 12, {32'h0, 32'hFF, 32'hFF, 32'hFF});
        access("R6 write iid", 1, 32'h08, 4, DW'(32'hFF));
        access("R6 write unmapped", 1, 32'h40, 4, DW'(32'hFF));
        access("R6 read fixed", 0, 32'h08, 16, '0);
        access("R6 read unmapped", 0, 32'hFFFC, 8, '0);

        // R7: rejected accesses
        access("R7 misaligned write", 1, 32'h1E, 4, DW'(32'h77));
        access("R7 odd length write", 1, 32'h1C, 6, DW'(32'h77));
        access("R7 tx rejected", 1, 32'h02, 4, DW'(32'h41));
        access("R7 misaligned read", 0, 32'h0D, 4, '0);
        access("R7 long read", 0, 32'h00, 20, '0);
        access("R7 state kept", 0, 32'h0C, 20'd0 + 16, '0);

        // R8 + R10: multi-word write with stalled sink, select flips at word 3
        tx_ready = 1'b0;
        fork
            access("R8 multi write", 1, 32'h00, 16,
                   {32'h80, 32'h0, 32'h33, 32'h5A});
            begin
                repeat (6) @(negedge clk);
                check(tx_valid && tx_data == 8'h5A, "R10 byte held",
                      128'({tx_valid, tx_data}), 128'({1'b1, 8'h5A}));
                check(!req_ready, "R10 no completion", 128'(req_ready), 128'(0));
                tx_ready = 1'b1;
            end
        join
        access("R8 multi read", 0, 32'h00, 16, '0);
        access("R8 mixed read", 0, 32'h10, 16, '0);

        // R11: zero-length request
        access("R11 zero length", 1, 32'h0C, 0, DW'(32'h00));
        access("R11 unchanged", 0, 32'h0C, 4, '0);

        repeat (3) @(negedge clk);
        check(tx_q.size() == 0, "R10 all bytes sent", 128'(tx_q.size()), 128'(0));
        finish_run();
    end

endmodule